// File: doc/BRIEF.md
# Per-CPU Highest-Priority Interrupt Selector

This block picks the single most urgent interrupt among the private sources of one processor. For each source it takes a pending latch, an edge or level trigger setting, the live level input, an enable, an active flag, a group bit, a group modifier and an 8-bit priority. It combines these with three global group enables and a global control that turns off the group modifier. From this it finds which sources may be signalled, then picks a winner. After the private sources it also weighs one externally supplied message-interrupt candidate, which has its own ID, priority and group code.

The selection is a sequential scan, and a single-cycle `start` pulse begins it. The state machine has three states. `ST_IDLE` waits for `start`. `ST_SCAN` visits one source per cycle in ascending ID order. `ST_MSG` weighs the message candidate, loads the result registers and pulses `done`. The transitions are:
- IDLE to SCAN on `start`.
- SCAN to SCAN while the index is below the last source.
- SCAN to MSG after the last source.
- MSG to IDLE unconditionally.

Between runs the result ports keep the previous outcome.

Top module: `ppi_hp_select`

## Requirements
- R1: A source is pending when its pending latch is 1, or when its trigger setting is 0 (level) and its level input is 1. With trigger setting 1 (edge), the level input has no effect.
- R2: A pending source is eligible only while its enable bit is 1 and its active bit is 0.
- R3: A source passes the group filter as follows:
  - group bit 1 passes when `en_grp1ns` is 1;
  - group bit 0 with effective modifier 1 passes when `en_grp1s` is 1;
  - group bit 0 with effective modifier 0 passes when `en_grp0` is 1.
- R4: While `sec_off` is 1, the effective modifier of every source is 0. This applies to both the filter and the reported group code.
- R5: A lower priority value wins. Among private sources of equal priority, the lowest ID wins.
- R6: Priority 0xFF means nothing is pending. A source or candidate at 0xFF never wins. With no winner, the outputs report priority 0xFF, ID 0, group code 0 and `win_valid` 0.
- R7: The message candidate is weighed only when `cpu_msg_en` and `glb_msg_en` are both 1 and `msg_prio` is not 0xFF. It wins on a strictly lower priority, or on equal priority when its ID is lower than or equal to the current winner's ID.
- R8: When the message candidate wins, `win_id`, `win_prio` and `win_grp` carry `msg_id`, `msg_prio` and `msg_grp` unchanged.
- R9: `busy` is 1 from the edge after `start` is sampled until the result is delivered. `done` is high for exactly one cycle, starting 33 clock edges after the edge that sampled `start`.
- R10: `win_valid` equals (`win_prio` != 0xFF). The result ports change only at the edge that raises `done`.
- R11: A `start` pulse while `busy` is 1 is ignored. It neither restarts the scan nor produces an extra `done`.
- R12: A private winner's group code is:
  - 2 when its group bit is 1;
  - 1 when its group bit is 0 and its effective modifier is 1;
  - 0 otherwise.
- R13: After reset, `win_valid`, `done` and `busy` are 0 and `win_prio` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a selection run (ignored while busy) |
| pend_latch | input | NUM_SRC | Per-source pending latch |
| edge_cfg | input | NUM_SRC | Per-source trigger setting: 1 edge, 0 level |
| level_in | input | NUM_SRC | Per-source live level input |
| src_en | input | NUM_SRC | Per-source enable |
| src_active | input | NUM_SRC | Per-source active flag |
| grp_bit | input | NUM_SRC | Per-source group bit |
| grp_mod | input | NUM_SRC | Per-source group modifier |
| prio_flat | input | NUM_SRC*PRIO_W | Priorities, source i at bits [i*PRIO_W +: PRIO_W] |
| en_grp0 | input | 1 | Enable for group 0 |
| en_grp1s | input | 1 | Enable for secure group 1 |
| en_grp1ns | input | 1 | Enable for non-secure group 1 |
| sec_off | input | 1 | Treat every group modifier as 0 |
| cpu_msg_en | input | 1 | Per-CPU message-interrupt enable |
| glb_msg_en | input | 1 | Global message-interrupt enable |
| msg_id | input | ID_W | Message candidate ID |
| msg_prio | input | PRIO_W | Message candidate priority |
| msg_grp | input | 2 | Message candidate group code |
| win_id | output | ID_W | Winning ID |
| win_prio | output | PRIO_W | Winning priority |
| win_grp | output | 2 | Winning group code |
| win_valid | output | 1 | A winner exists |
| done | output | 1 | One-cycle result pulse |
| busy | output | 1 | Scan in progress |

## Verification
The bench builds the block with its default parameters: 32 private sources, 8-bit priorities and 16-bit IDs. With these values the full 32-step walk and the final message step are exercised, including the wrap of the 5-bit index after source 31. The 16-bit ID width lets message IDs sit either far above the private range or inside it. That makes the tie rule against a private winner reachable from both sides. Directed cases cover each filter term, the modifier override and the message gating; randomized runs mix all of them.

// File: rtl/ppi_sel_pkg.sv
package ppi_sel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_MSG
    } sel_state_e;

    localparam logic [1:0] GC_G0   = 2'd0;
    localparam logic [1:0] GC_G1S  = 2'd1;
    localparam logic [1:0] GC_G1NS = 2'd2;

    // Group code of a private source from its group bit and effective modifier
    function automatic logic [1:0] grp_code(input logic g, input logic m);
        if (g)      return GC_G1NS;
        else if (m) return GC_G1S;
        else        return GC_G0;
    endfunction

endpackage

// File: rtl/ppi_elig.sv
module ppi_elig #(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0] pend_latch,
    input  logic [NUM_SRC-1:0] edge_cfg,
    input  logic [NUM_SRC-1:0] level_in,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] src_active,
    input  logic [NUM_SRC-1:0] grp_bit,
    input  logic [NUM_SRC-1:0] grp_mod,
    input  logic               en_grp0,
    input  logic               en_grp1s,
    input  logic               en_grp1ns,
    input  logic               sec_off,
    output logic [NUM_SRC-1:0] eff_mod,
    output logic [NUM_SRC-1:0] elig
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic pend_i;
        logic pass_i;
        assign pend_i     = pend_latch[i] | (~edge_cfg[i] & level_in[i]);
        assign eff_mod[i] = grp_mod[i] & ~sec_off;
        assign pass_i     = (grp_bit[i] & en_grp1ns)
                          | (~grp_bit[i] & eff_mod[i] & en_grp1s)
                          | (~grp_bit[i] & ~eff_mod[i] & en_grp0);
        assign elig[i]    = pend_i & src_en[i] & ~src_active[i] & pass_i;
    end
endmodule

// File: rtl/ppi_better.sv
module ppi_better #(
    parameter int PRIO_W = 8,
    parameter int ID_W   = 16
) (
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic [ID_W-1:0]   cur_id,
    input  logic              tie_ok,
    output logic              better
);
    assign better = (cand_prio < cur_prio)
                  || (tie_ok && (cand_prio == cur_prio) && (cand_id <= cur_id));
endmodule

// File: rtl/ppi_hp_select.sv
module ppi_hp_select
    import ppi_sel_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 8,
    parameter int ID_W    = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [NUM_SRC-1:0]        pend_latch,
    input  logic [NUM_SRC-1:0]        edge_cfg,
    input  logic [NUM_SRC-1:0]        level_in,
    input  logic [NUM_SRC-1:0]        src_en,
    input  logic [NUM_SRC-1:0]        src_active,
    input  logic [NUM_SRC-1:0]        grp_bit,
    input  logic [NUM_SRC-1:0]        grp_mod,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic                      en_grp0,
    input  logic                      en_grp1s,
    input  logic                      en_grp1ns,
    input  logic                      sec_off,
    input  logic                      cpu_msg_en,
    input  logic                      glb_msg_en,
    input  logic [ID_W-1:0]           msg_id,
    input  logic [PRIO_W-1:0]         msg_prio,
    input  logic [1:0]                msg_grp,
    output logic [ID_W-1:0]           win_id,
    output logic [PRIO_W-1:0]         win_prio,
    output logic [1:0]                win_grp,
    output logic                      win_valid,
    output logic                      done,
    output logic                      busy
);
    localparam int                IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_SRC - 1);
    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

    sel_state_e        state, state_nx;
    logic [IDX_W-1:0]  idx;
    logic [ID_W-1:0]   acc_id;
    logic [PRIO_W-1:0] acc_prio;
    logic [1:0]        acc_grp;

    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] eff_mod;
    logic [PRIO_W-1:0]  scan_prio;
    logic [ID_W-1:0]    scan_id;
    logic               scan_better;
    logic               msg_better;
    logic               msg_take;
    logic [ID_W-1:0]    fin_id;
    logic [PRIO_W-1:0]  fin_prio;
    logic [1:0]         fin_grp;

    ppi_elig #(.NUM_SRC(NUM_SRC)) u_elig (
        .pend_latch (pend_latch),
        .edge_cfg   (edge_cfg),
        .level_in   (level_in),
        .src_en     (src_en),
        .src_active (src_active),
        .grp_bit    (grp_bit),
        .grp_mod    (grp_mod),
        .en_grp0    (en_grp0),
        .en_grp1s   (en_grp1s),
        .en_grp1ns  (en_grp1ns),
        .sec_off    (sec_off),
        .eff_mod    (eff_mod),
        .elig       (elig)
    );

    assign scan_prio = prio_flat[int'(idx)*PRIO_W +: PRIO_W];
    assign scan_id   = ID_W'(idx);

    // Ascending walk: strict less keeps the lowest ID on ties
    ppi_better #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_scan_cmp (
        .cand_prio (scan_prio),
        .cand_id   (scan_id),
        .cur_prio  (acc_prio),
        .cur_id    (acc_id),
        .tie_ok    (1'b0),
        .better    (scan_better)
    );

    ppi_better #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_msg_cmp (
        .cand_prio (msg_prio),
        .cand_id   (msg_id),
        .cur_prio  (acc_prio),
        .cur_id    (acc_id),
        .tie_ok    (1'b1),
        .better    (msg_better)
    );

    always_comb begin
        msg_take = cpu_msg_en && glb_msg_en && (msg_prio != PRIO_NONE) && msg_better;
        fin_id   = msg_take ? msg_id   : acc_id;
        fin_prio = msg_take ? msg_prio : acc_prio;
        fin_grp  = msg_take ? msg_grp  : acc_grp;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_SCAN;
            ST_SCAN: if (idx == LAST_IDX) state_nx = ST_MSG;
            ST_MSG:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            acc_id    <= '0;
            acc_prio  <= PRIO_NONE;
            acc_grp   <= GC_G0;
            win_id    <= '0;
            win_prio  <= PRIO_NONE;
            win_grp   <= GC_G0;
            win_valid <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        idx      <= '0;
                        acc_id   <= '0;
                        acc_prio <= PRIO_NONE;
                        acc_grp  <= GC_G0;
                    end
                end
                ST_SCAN: begin
                    if (elig[idx] && scan_better) begin
                        acc_id   <= scan_id;
                        acc_prio <= scan_prio;
                        acc_grp  <= grp_code(grp_bit[idx], eff_mod[idx]);
                    end
                    idx <= idx + 1'b1;
                end
                ST_MSG: begin
                    win_id    <= fin_id;
                    win_prio  <= fin_prio;
                    win_grp   <= fin_grp;
                    win_valid <= (fin_prio != PRIO_NONE);
                    done      <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && idx != LAST_IDX) |=> (state == ST_SCAN && idx == IDX_W'($past(idx) + 1'b1))); // R11
    AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (state == ST_SCAN && idx == '0)); // R9
    AST_VALID_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid == (win_prio != PRIO_NONE)); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(win_prio) && $stable(win_id) && $stable(win_grp))); // R10
    AST_MSG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(cpu_msg_en && glb_msg_en)) |-> (!win_valid || win_id < ID_W'(NUM_SRC))); // R7
endmodule

// File: tb/tb_ppi_hp_select.sv
`timescale 1ns/1ps
module tb_ppi_hp_select;
    localparam int N  = 32;
    localparam int PW = 8;
    localparam int IW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N-1:0] pend_latch = '0, edge_cfg = '0, level_in = '0, src_en = '0;
    logic [N-1:0] src_active = '0, grp_bit = '0, grp_mod = '0;
    logic [PW-1:0] prio_a [N];
    logic [N*PW-1:0] prio_flat;
    logic en_grp0 = 0, en_grp1s = 0, en_grp1ns = 0, sec_off = 0;
    logic cpu_msg_en = 0, glb_msg_en = 0;
    logic [IW-1:0] msg_id = '0;
    logic [PW-1:0] msg_prio = '1;
    logic [1:0] msg_grp = '0;
    logic [IW-1:0] win_id;
    logic [PW-1:0] win_prio;
    logic [1:0] win_grp;
    logic win_valid, done, busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        logic [IW-1:0] id;
        logic [PW-1:0] prio;
        logic [1:0]    grp;
        logic          v;
        int            due;
    } exp_t;
    exp_t sb_q[$];
    exp_t last_exp;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always_comb for (int i = 0; i < N; i++) prio_flat[i*PW +: PW] = prio_a[i];

    ppi_hp_select #(.NUM_SRC(N), .PRIO_W(PW), .ID_W(IW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pend_latch(pend_latch), .edge_cfg(edge_cfg), .level_in(level_in),
        .src_en(src_en), .src_active(src_active), .grp_bit(grp_bit), .grp_mod(grp_mod),
        .prio_flat(prio_flat), .en_grp0(en_grp0), .en_grp1s(en_grp1s), .en_grp1ns(en_grp1ns),
        .sec_off(sec_off), .cpu_msg_en(cpu_msg_en), .glb_msg_en(glb_msg_en),
        .msg_id(msg_id), .msg_prio(msg_prio), .msg_grp(msg_grp),
        .win_id(win_id), .win_prio(win_prio), .win_grp(win_grp), .win_valid(win_valid),
        .done(done), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Reference selection computed from the requirements
    function automatic exp_t model();
        exp_t e;
        e.prio = '1; e.id = '0; e.grp = 2'd0;
        for (int i = 0; i < N; i++) begin
            logic p, m, gp;
            p  = pend_latch[i] | (!edge_cfg[i] & level_in[i]);   // R1
            m  = grp_mod[i] & !sec_off;                          // R4
            gp = grp_bit[i] ? en_grp1ns : (m ? en_grp1s : en_grp0); // R3
            if (p && src_en[i] && !src_active[i] && gp && prio_a[i] < e.prio) begin // R2 R5
                e.prio = prio_a[i];
                e.id   = IW'(i);
                e.grp  = grp_bit[i] ? 2'd2 : (m ? 2'd1 : 2'd0);  // R12
            end
        end
        if (cpu_msg_en && glb_msg_en && msg_prio != '1 &&
            (msg_prio < e.prio || (msg_prio == e.prio && msg_id <= e.id))) begin // R7
            e.prio = msg_prio; e.id = msg_id; e.grp = msg_grp;  // R8
        end
        e.v = (e.prio != '1);  // R6
        e.due = 0;
        return e;
    endfunction

    // Monitor: pops expected results as done pulses appear
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R11 unexpected done", 32'(done), 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(cyc == e.due, "R9 done timing", 32'(cyc), 32'(e.due));
                chk(win_valid == e.v, "R6 valid", 32'(win_valid), 32'(e.v));
                chk(win_prio == e.prio, "R5 prio", 32'(win_prio), 32'(e.prio));
                chk(win_id == e.id, "R5 id", 32'(win_id), 32'(e.id));
                chk(win_grp == e.grp, "R12 group", 32'(win_grp), 32'(e.grp));
                chk(!busy, "R9 busy clear at done", 32'(busy), 32'd0);
            end
        end
    end

    // Driver: pushes expected result, pulses start, waits for completion
    task automatic run_case(input bit restart_mid);
        exp_t e;
        @(negedge clk);
        e = model();
        e.due = cyc + 34;
        sb_q.push_back(e);
        last_exp = e;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R9 busy after start", 32'(busy), 32'd1);
        repeat (10) @(negedge clk);
        if (restart_mid) begin
            start = 1'b1;  // R11: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic clear_cfg();
        pend_latch = '0; edge_cfg = '0; level_in = '0; src_en = '0;
        src_active = '0; grp_bit = '0; grp_mod = '0;
        en_grp0 = 0; en_grp1s = 0; en_grp1ns = 0; sec_off = 0;
        cpu_msg_en = 0; glb_msg_en = 0; msg_id = '0; msg_prio = '1; msg_grp = '0;
        for (int i = 0; i < N; i++) prio_a[i] = 8'h80;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 32'(cyc), 32'd0);
        summary();
    end

    initial begin
        clear_cfg();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(!win_valid, "R13 valid", 32'(win_valid), 32'd0);
        chk(win_prio == 8'hFF, "R13 prio", 32'(win_prio), 32'hFF);
        chk(!done, "R13 done", 32'(done), 32'd0);
        chk(!busy, "R13 busy", 32'(busy), 32'd0);

        // R5: distinct priorities, lowest value wins
        pend_latch = '1; src_en = '1; grp_bit = '1; en_grp1ns = 1;
        for (int i = 0; i < N; i++) prio_a[i] = 8'(100 + i);
        prio_a[17] = 8'h10;
        run_case(0);

        // R5: tie goes to lowest ID
        for (int i = 0; i < N; i++) prio_a[i] = 8'h40;
        prio_a[3] = 8'h20; prio_a[9] = 8'h20; prio_a[30] = 8'h20;
        run_case(0);

        // R1: level vs edge trigger
        clear_cfg(); en_grp1ns = 1; grp_bit = '1; src_en = '1;
        level_in[5] = 1; edge_cfg[5] = 1; prio_a[5] = 8'h01;   // edge: not pending
        level_in[12] = 1; edge_cfg[12] = 0; prio_a[12] = 8'h30; // level: pending
        run_case(0);

        // R2: enable and active filtering
        pend_latch = '1; src_active[12] = 1; src_en[2] = 0; prio_a[2] = 8'h00;
        prio_a[20] = 8'h50;
        run_case(0);

        // R3/R12: groups with only group 0 enabled, then only secure group 1
        clear_cfg(); pend_latch = '1; src_en = '1;
        grp_bit[1] = 1; prio_a[1] = 8'h05;
        grp_mod[4] = 1; prio_a[4] = 8'h06;
        prio_a[7] = 8'h07;
        en_grp0 = 1;
        run_case(0);
        en_grp0 = 0; en_grp1s = 1;
        run_case(0);
        en_grp1s = 0; en_grp1ns = 1;
        run_case(0);

        // R4: override forces modifier to 0
        en_grp1ns = 0; en_grp0 = 1; sec_off = 1;
        run_case(0);

        // R6: nothing eligible, and an eligible source at 0xFF
        clear_cfg(); en_grp0 = 1; src_en = '1;
        run_case(0);
        pend_latch[8] = 1; prio_a[8] = 8'hFF;
        run_case(0);

        // R7/R8: message candidate wins
        pend_latch[8] = 1; prio_a[8] = 8'h40;
        cpu_msg_en = 1; glb_msg_en = 1; msg_id = 16'h2005; msg_prio = 8'h10; msg_grp = 2'd3;
        run_case(0);
        // R7 gated by each enable and by 0xFF
        cpu_msg_en = 0; run_case(0);
        cpu_msg_en = 1; glb_msg_en = 0; run_case(0);
        glb_msg_en = 1; msg_prio = 8'hFF; run_case(0);
        // R7 ties: higher message ID loses, lower-or-equal wins
        msg_prio = 8'h40; run_case(0);
        msg_id = 16'd8; run_case(0);
        // R7: message alone with no private winner
        pend_latch = '0; msg_id = 16'h3000; msg_prio = 8'hFE; msg_grp = 2'd1; run_case(0);

        // R11: start during busy ignored
        run_case(1);

        // R10: results hold after inputs change
        pend_latch = '1; src_en = '1; en_grp1ns = 1; en_grp1s = 1; grp_bit = '1;
        for (int i = 0; i < N; i++) prio_a[i] = 8'h00;
        repeat (6) @(negedge clk);
        chk(win_prio == last_exp.prio, "R10 hold prio", 32'(win_prio), 32'(last_exp.prio));
        chk(win_id == last_exp.id, "R10 hold id", 32'(win_id), 32'(last_exp.id));
        chk(win_valid == last_exp.v, "R10 hold valid", 32'(win_valid), 32'(last_exp.v));

        // Randomized mixes
        for (int r = 0; r < 40; r++) begin
            pend_latch = $urandom & $urandom; edge_cfg = $urandom; level_in = $urandom;
            src_en = $urandom | $urandom; src_active = $urandom & $urandom;
            grp_bit = $urandom; grp_mod = $urandom;
            for (int i = 0; i < N; i++) prio_a[i] = ($urandom % 5 == 0) ? 8'hFF : 8'($urandom % 24);
            en_grp0 = 1'($urandom); en_grp1s = 1'($urandom); en_grp1ns = 1'($urandom);
            sec_off = 1'($urandom); cpu_msg_en = 1'($urandom); glb_msg_en = 1'($urandom);
            msg_id = ($urandom % 2 == 0) ? 16'($urandom % 32) : 16'(16'h2000 + $urandom % 512);
            msg_prio = 8'($urandom % 24); msg_grp = 2'($urandom);
            run_case(r % 7 == 0);
        end

        repeat (40) @(negedge clk);
        chk(sb_q.size() == 0, "R9 all results delivered", 32'(sb_q.size()), 32'd0);
        summary();
    end
endmodule